// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Victim Selector

This block holds the replacement bookkeeping for a four-way set-associative cache. Each set is tracked with a three-bit binary tree instead of a full recency order. A root bit steers toward one half of the set. Two pair bits then steer toward one way inside the lower pair (ways 0 and 1) or the upper pair (ways 2 and 3). Every access moves the root and the bit of the accessed pair so that both point away from the way that was just used. The bit of the other pair is left as it was.

The cache controller reports each access with a set number and a way number. Independently, it presents a set number on the query side and receives the way to evict from that set, with no clock delay. Tags, data, hit detection and refill traffic all live outside this block. The tree only approximates recency, so the selected way is sometimes not the line used longest ago.

Top module: `plru4_sel`

## Requirements
- R1: A synchronous reset clears the tree of every set, so that any queried set reports way 0. An access presented in the same cycle as reset is discarded.
- R2: Each set stores three bits: root, lower-pair bit and upper-pair bit. The set count is 2^SET_W, with SET_W = 4 by default (16 sets).
- R3: A valid access to way 0 sets the root to 1 and the lower-pair bit to 1. A following query of that set then reports way 2 or way 3.
- R4: A valid access to way 1 sets the root to 1 and the lower-pair bit to 0.
- R5: A valid access to way 2 sets the root to 0 and the upper-pair bit to 1. A valid access to way 3 sets the root to 0 and the upper-pair bit to 0. After either one, a following query of that set reports way 0 or way 1.
- R6: An access leaves the pair bit of the other pair unchanged.
- R7: The victim decode works as follows. With root = 1, upper-pair bit 1 gives way 3 and upper-pair bit 0 gives way 2. With root = 0, lower-pair bit 1 gives way 1 and lower-pair bit 0 gives way 0. Way numbers on victim_way are plain binary.
- R8: An access to one set leaves the tree of every other set unchanged.
- R9: With access_valid low, no set changes, whatever access_set and access_way carry.
- R10: An update takes effect at the clock edge. A query of the same set in the cycle of the access reports the victim from before the update.
- R11: From reset, accesses to one set in the order way 1, way 3, way 2, way 0 leave that set reporting way 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| access_valid | input | 1 | Qualifies an access this cycle |
| access_set | input | SET_W | Set number of the access |
| access_way | input | 2 | Way number of the access, binary 0 to 3 |
| query_set | input | SET_W | Set whose victim is requested |
| victim_way | output | 2 | Way to evict from query_set, combinational |

## Verification
Two things can fall in the same cycle: an update to a set and a query of that same set. The bench provokes this by driving the access and the query together. It samples victim_way before the edge and expects the old victim. After the edge it expects the new victim. A reset that arrives together with a valid access is also provoked, and it is judged by every set reporting way 0 afterwards.

// File: rtl/plru4_pkg.sv
package plru4_pkg;

   localparam int unsigned WAY_W   = 2;
   localparam int unsigned TREE_W  = 3;

   // Tree state of one set.
   // root : 1 -> victim in upper pair (ways 2/3), 0 -> lower pair (ways 0/1)
   // lo   : within lower pair, 1 -> way 1, 0 -> way 0
   // hi   : within upper pair, 1 -> way 3, 0 -> way 2
   typedef struct packed {
      logic hi;
      logic lo;
      logic root;
   } tree_t;

   localparam tree_t TREE_RST = '{hi: 1'b0, lo: 1'b0, root: 1'b0};

endpackage

// File: rtl/plru4_update.sv
module plru4_update
   import plru4_pkg::*;
(
   input  tree_t             cur_tree,
   input  logic [WAY_W-1:0]  touch_way,
   output tree_t             nxt_tree
);

   // Point the root and the touched pair away from the touched way;
   // the other pair bit is carried through.
   always_comb begin
      nxt_tree = cur_tree;
      unique case (touch_way)
         2'd0: begin
            nxt_tree.root = 1'b1;
            nxt_tree.lo   = 1'b1;
         end
         2'd1: begin
            nxt_tree.root = 1'b1;
            nxt_tree.lo   = 1'b0;
         end
         2'd2: begin
            nxt_tree.root = 1'b0;
            nxt_tree.hi   = 1'b1;
         end
         default: begin
            nxt_tree.root = 1'b0;
            nxt_tree.hi   = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/plru4_victim.sv
module plru4_victim
   import plru4_pkg::*;
#(
   parameter bit MUX_DECODE = 1'b1
)
(
   input  tree_t             tree,
   output logic [WAY_W-1:0]  victim
);

   generate
      if (MUX_DECODE) begin : g_mux
         always_comb begin
            if (tree.root)
               victim = tree.hi ? 2'd3 : 2'd2;
            else
               victim = tree.lo ? 2'd1 : 2'd0;
         end
      end else begin : g_gate
         // MSB is the half choice; LSB is the pair bit of that half.
         assign victim[1] = tree.root;
         assign victim[0] = (tree.root & tree.hi) | (~tree.root & tree.lo);
      end
   endgenerate

endmodule

// File: rtl/plru4_store.sv
module plru4_store
   import plru4_pkg::*;
#(
   parameter int unsigned SET_W = 4,
   localparam int unsigned NUM_SETS = 1 << SET_W
)
(
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [SET_W-1:0]  wr_set,
   input  tree_t             wr_tree,
   input  logic [SET_W-1:0]  rd_a_set,
   output tree_t             rd_a_tree,
   input  logic [SET_W-1:0]  rd_b_set,
   output tree_t             rd_b_tree
);

   tree_t bank [NUM_SETS];

   generate
      for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
         logic sel;
         assign sel = wr_en && (wr_set == SET_W'(g));
         always_ff @(posedge clk) begin
            if (rst)
               bank[g] <= TREE_RST;
            else if (sel)
               bank[g] <= wr_tree;
         end
      end
   endgenerate

   assign rd_a_tree = bank[rd_a_set];
   assign rd_b_tree = bank[rd_b_set];

endmodule

// File: rtl/plru4_sel.sv
module plru4_sel
   import plru4_pkg::*;
#(
   parameter int unsigned SET_W      = 4,
   parameter bit          MUX_DECODE = 1'b1
)
(
   input  logic              clk,
   input  logic              rst,
   input  logic              access_valid,
   input  logic [SET_W-1:0]  access_set,
   input  logic [1:0]        access_way,
   input  logic [SET_W-1:0]  query_set,
   output logic [1:0]        victim_way
);

   generate
      if (SET_W < 1 || SET_W > 10) begin : g_bad_set_w
         $error("plru4_sel: SET_W must lie in 1..10");
      end
      if (WAY_W != 2 || TREE_W != 3) begin : g_bad_tree
         $error("plru4_sel: tree layout supports four ways only");
      end
   endgenerate

   tree_t acc_tree;
   tree_t acc_next;
   tree_t qry_tree;

   plru4_store #(.SET_W(SET_W)) u_store (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (access_valid),
      .wr_set    (access_set),
      .wr_tree   (acc_next),
      .rd_a_set  (access_set),
      .rd_a_tree (acc_tree),
      .rd_b_set  (query_set),
      .rd_b_tree (qry_tree)
   );

   plru4_update u_update (
      .cur_tree  (acc_tree),
      .touch_way (access_way),
      .nxt_tree  (acc_next)
   );

   plru4_victim #(.MUX_DECODE(MUX_DECODE)) u_victim (
      .tree   (qry_tree),
      .victim (victim_way)
   );

endmodule

// File: rtl/plru4_sel_chk.sv
module plru4_sel_chk #(
   parameter int unsigned SET_W = 4
)
(
   input  logic              clk,
   input  logic              rst,
   input  logic              access_valid,
   input  logic [SET_W-1:0]  access_set,
   input  logic [1:0]        access_way,
   input  logic [SET_W-1:0]  query_set,
   input  logic [1:0]        victim_way
);

   // R1: the first cycle after reset reports way 0 for any set
   a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> victim_way == 2'd0);

   // R3, R4: an access to way 0 or 1 sends the next victim of that set to the upper pair
   a_r3_upper_after_low_way: assert property (@(posedge clk) disable iff (rst)
      ($past(access_valid && !rst && !access_way[1]) && query_set == $past(access_set))
      |-> victim_way[1]);

   // R5: an access to way 2 or 3 sends the next victim of that set to the lower pair
   a_r5_lower_after_high_way: assert property (@(posedge clk) disable iff (rst)
      ($past(access_valid && !rst && access_way[1]) && query_set == $past(access_set))
      |-> !victim_way[1]);

   // R7: the decoded victim is always a known way number
   a_r7_known_victim: assert property (@(posedge clk) disable iff (rst)
      !$isunknown(victim_way));

   // R8: an access to another set leaves the queried set alone
   a_r8_other_set_hold: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(access_valid) && $stable(query_set)
       && query_set != $past(access_set)) |-> $stable(victim_way));

   // R9: no valid access, no change
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(access_valid) && $stable(query_set)) |-> $stable(victim_way));

endmodule

bind plru4_sel plru4_sel_chk #(.SET_W(SET_W)) u_chk (.*);

// File: tb/tb_plru4_sel.sv
`timescale 1ns/1ps
module tb_plru4_sel;

   localparam int unsigned SET_W = 4;
   localparam int unsigned NSETS = 1 << SET_W;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             access_valid = 1'b0;
   logic [SET_W-1:0] access_set = '0;
   logic [1:0]       access_way = '0;
   logic [SET_W-1:0] query_set = '0;
   logic [1:0]       victim_way;

   int nchk  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   plru4_sel #(.SET_W(SET_W)) dut (
      .clk          (clk),
      .rst          (rst),
      .access_valid (access_valid),
      .access_set   (access_set),
      .access_way   (access_way),
      .query_set    (query_set),
      .victim_way   (victim_way)
   );

   typedef struct packed {
      logic       v;
      logic [3:0] s;
      logic [1:0] w;
      logic [3:0] q;
      logic [1:0] e;
      logic [3:0] r;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 4'd0,  2'd1, 4'd0,  2'd2, 4'd4},   // R4: root=1 lo=0 hi=0
      '{1'b1, 4'd0,  2'd3, 4'd0,  2'd0, 4'd5},   // R5: root=0 hi=0
      '{1'b1, 4'd0,  2'd2, 4'd0,  2'd0, 4'd5},   // R5: root=0 hi=1 lo=0
      '{1'b1, 4'd0,  2'd0, 4'd0,  2'd3, 4'd11},  // R11: order 1,3,2,0 -> way 3
      '{1'b1, 4'd5,  2'd0, 4'd5,  2'd2, 4'd3},   // R3: root=1 lo=1 hi=0
      '{1'b1, 4'd5,  2'd2, 4'd5,  2'd1, 4'd6},   // R6: lo kept at 1
      '{1'b1, 4'd5,  2'd1, 4'd5,  2'd3, 4'd6},   // R6: hi kept at 1
      '{1'b1, 4'd5,  2'd3, 4'd5,  2'd0, 4'd7},   // R7: all zero -> way 0
      '{1'b1, 4'd9,  2'd0, 4'd5,  2'd0, 4'd8},   // R8: set 5 unaffected
      '{1'b0, 4'd9,  2'd3, 4'd9,  2'd2, 4'd9},   // R9: invalid access ignored
      '{1'b1, 4'd9,  2'd2, 4'd9,  2'd1, 4'd7},   // R7: root=0 lo=1 -> way 1
      '{1'b1, 4'd15, 2'd3, 4'd15, 2'd0, 4'd5},   // R5: top set index
      '{1'b1, 4'd15, 2'd1, 4'd15, 2'd2, 4'd7},   // R7: root=1 hi=0 -> way 2
      '{1'b0, 4'd0,  2'd0, 4'd3,  2'd0, 4'd1}    // R1: untouched set
   };

   task automatic check(input logic [1:0] exp, input string req);
      nchk++;
      if (victim_way !== exp) begin
         nfail++;
         $display("FAIL %s: victim_way=%0d expected=%0d", req, victim_way, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: reset state of every set
      for (int i = 0; i < NSETS; i++) begin
         query_set = SET_W'(i);
         #1 check(2'd0, "R1 reset state");
      end

      // table walk: access for one edge, then query
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         access_valid = VEC[k].v;
         access_set   = VEC[k].s;
         access_way   = VEC[k].w;
         @(posedge clk);
         #1;
         access_valid = 1'b0;
         query_set    = VEC[k].q;
         #1 check(VEC[k].e, $sformatf("R%0d vector %0d", VEC[k].r, k));
      end

      // R10: update and query of the same set in one cycle (set 9: victim 1)
      @(negedge clk);
      access_valid = 1'b1;
      access_set   = 4'd9;
      access_way   = 2'd1;
      query_set    = 4'd9;
      #1 check(2'd1, "R10 pre-update value in access cycle");
      @(posedge clk);
      #1;
      access_valid = 1'b0;
      #1 check(2'd3, "R10 post-update value (R4 path)");

      // R2: independent storage for each set, highest and lowest index
      query_set = 4'd15;
      #1 check(2'd2, "R2 set 15 state kept");
      query_set = 4'd0;
      #1 check(2'd3, "R2 set 0 state kept");

      // R1: reset together with a valid access clears everything
      @(negedge clk);
      rst          = 1'b1;
      access_valid = 1'b1;
      access_set   = 4'd0;
      access_way   = 2'd0;
      @(posedge clk);
      #1;
      rst          = 1'b0;
      access_valid = 1'b0;
      for (int i = 0; i < NSETS; i++) begin
         query_set = SET_W'(i);
         #1 check(2'd0, "R1 reset with access");
      end

      done = 1'b1;
      finish_run();
   end

endmodule